// File: doc/BRIEF.md
# Acquisition Mode Supervisor

This block tracks the operating mode of a detector acquisition module and the mode of the video conversion chain that the module feeds. The module layer has three modes: unpowered, powered with detector biases up but no clocking, and sequencing, where the detector is clocked. The video layer has four modes: idle with no video data, test ramp, calibration, and operational capture. Each layer takes its own mode-change command as a valid strobe plus a two-bit code.

Every command is checked against the rules that link the two layers. A legal command takes effect at the next rising clock edge. An illegal command leaves both layers unchanged and sets a sticky error flag, which the host clears. The block drives the bias enable and the detector sequencing enable. It reports both current modes as encoded status fields. Operational capture is only reachable while the detector is being sequenced. If sequencing stops while capture is running, the video layer is forced back to idle.

Top module: `acq_mode_supervisor`

## Requirements
- R1: Module mode codes are OFF=0, ON=1, SEQUENCED=2, and code 3 is never reported. Video mode codes are IDLE=0, RAMP=1, CAL=2, OPER=3. After reset the module is OFF, the video layer is IDLE, and the error flag, bias enable and sequencing enable are all 0.
- R2: In OFF, bias enable and sequencing enable are 0 and the video layer is IDLE. The only legal way out of OFF is a request for ON. A request for OFF while in OFF is a legal no-op. Every video request made while in OFF is illegal.
- R3: In ON, bias enable is 1 and sequencing enable is 0. Requests for OFF, ON and SEQUENCED are legal.
- R4: In SEQUENCED, bias enable and sequencing enable are both 1. Requests for OFF, ON and SEQUENCED are legal.
- R5: From IDLE, RAMP and CAL are legal in both ON and SEQUENCED. OPER is legal only in SEQUENCED.
- R6: From RAMP, CAL or OPER, the only legal change is back to IDLE. A request for the current video mode is a legal no-op.
- R7: A change from SEQUENCED to ON while the video layer is OPER forces the video layer to IDLE. Any other video mode is kept. Any change to OFF forces the video layer to IDLE.
- R8: An illegal request, including module code 3, leaves both modes unchanged and sets the error flag one cycle later.
- R9: The error flag stays set until err_clr_i is asserted. If a new illegal request arrives in the same cycle as the clear, the flag stays set.
- R10: If a module request and a video request are valid in the same cycle, the module request is applied and the video request is rejected as illegal.
- R11: A legal request shows on the status outputs after the first rising edge at which it is sampled, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mod_req_valid_i | input | 1 | Module mode request strobe |
| mod_req_i | input | 2 | Requested module mode code |
| vid_req_valid_i | input | 1 | Video mode request strobe |
| vid_req_i | input | 2 | Requested video mode code |
| err_clr_i | input | 1 | Clears the sticky error flag |
| bias_en_o | output | 1 | Detector bias enable |
| seq_en_o | output | 1 | Detector sequencing enable |
| mod_state_o | output | 2 | Current module mode code |
| vid_state_o | output | 2 | Current video mode code |
| err_o | output | 1 | Sticky illegal-request flag |

## Verification
The hardest case to reach is the forced fall from OPER to IDLE. It needs the module in SEQUENCED and the video layer already in OPER before the module request arrives. The bench therefore builds each starting pair of modes with a reset followed by a short chain of legal requests. It then sweeps every module code and every video code from each reachable pair of modes, and compares the outcome against a rule-by-rule model. Collisions between the two request strobes, and a clear that arrives together with a new fault, are driven on purpose after that sweep.

// File: rtl/acq_mode_pkg.sv
package acq_mode_pkg;
  localparam int ModW = 2;
  localparam int VidW = 2;

  typedef enum logic [ModW-1:0] {
    MOD_OFF = 2'd0,
    MOD_ON  = 2'd1,
    MOD_SEQ = 2'd2,
    MOD_BAD = 2'd3
  } mod_e;

  typedef enum logic [VidW-1:0] {
    VID_IDLE = 2'd0,
    VID_RAMP = 2'd1,
    VID_CAL  = 2'd2,
    VID_OPER = 2'd3
  } vid_e;
endpackage

// File: rtl/mod_layer_ctrl.sv
module mod_layer_ctrl
  import acq_mode_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic [ModW-1:0] req_i,
  output mod_e            mod_q_o,
  output mod_e            mod_nxt_o,
  output logic            bad_o
);
  mod_e mod_q, mod_nxt, req;
  logic bad;

  assign req = mod_e'(req_i);

  always_comb begin
    mod_nxt = mod_q;
    bad     = 1'b0;
    if (req_valid_i) begin
      if (req == MOD_BAD) begin
        bad = 1'b1;
      end else if (mod_q == MOD_OFF && req == MOD_SEQ) begin
        bad = 1'b1;  // OFF exits only to ON
      end else begin
        mod_nxt = req;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mod_q <= MOD_OFF;
    else         mod_q <= mod_nxt;
  end

  assign mod_q_o   = mod_q;
  assign mod_nxt_o = mod_nxt;
  assign bad_o     = bad;
endmodule

// File: rtl/vid_layer_ctrl.sv
module vid_layer_ctrl
  import acq_mode_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  mod_e            mod_q_i,
  input  mod_e            mod_nxt_i,
  input  logic            mod_req_valid_i,
  input  logic            req_valid_i,
  input  logic [VidW-1:0] req_i,
  output vid_e            vid_q_o,
  output logic            bad_o
);
  vid_e vid_q, vid_nxt, req;
  logic bad;

  assign req = vid_e'(req_i);

  always_comb begin
    vid_nxt = vid_q;
    bad     = 1'b0;
    if (req_valid_i) begin
      if (mod_req_valid_i || mod_q_i == MOD_OFF) begin
        bad = 1'b1;  // collision or unpowered
      end else if (req == vid_q) begin
        vid_nxt = vid_q;
      end else if (vid_q == VID_IDLE) begin
        if (req == VID_OPER && mod_q_i != MOD_SEQ) bad = 1'b1;
        else                                       vid_nxt = req;
      end else if (req == VID_IDLE) begin
        vid_nxt = VID_IDLE;
      end else begin
        bad = 1'b1;
      end
    end
    // forced fallback on module changes
    if (mod_nxt_i == MOD_OFF) begin
      vid_nxt = VID_IDLE;
    end else if (mod_q_i == MOD_SEQ && mod_nxt_i == MOD_ON && vid_q == VID_OPER) begin
      vid_nxt = VID_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vid_q <= VID_IDLE;
    else         vid_q <= vid_nxt;
  end

  assign vid_q_o = vid_q;
  assign bad_o   = bad;
endmodule

// File: rtl/err_latch.sv
module err_latch #(
  parameter int NumSrc = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NumSrc-1:0] set_i,
  input  logic              clr_i,
  output logic              err_o
);
  logic err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     err_q <= 1'b0;
    else if (|set_i) err_q <= 1'b1;  // set wins over clear
    else if (clr_i)  err_q <= 1'b0;
  end

  assign err_o = err_q;
endmodule

// File: rtl/acq_mode_supervisor.sv
module acq_mode_supervisor
  import acq_mode_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mod_req_valid_i,
  input  logic [ModW-1:0] mod_req_i,
  input  logic            vid_req_valid_i,
  input  logic [VidW-1:0] vid_req_i,
  input  logic            err_clr_i,
  output logic            bias_en_o,
  output logic            seq_en_o,
  output logic [ModW-1:0] mod_state_o,
  output logic [VidW-1:0] vid_state_o,
  output logic            err_o
);
  mod_e mod_q, mod_nxt;
  vid_e vid_q;
  logic mod_bad, vid_bad;

  mod_layer_ctrl u_mod (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (mod_req_valid_i),
    .req_i       (mod_req_i),
    .mod_q_o     (mod_q),
    .mod_nxt_o   (mod_nxt),
    .bad_o       (mod_bad)
  );

  vid_layer_ctrl u_vid (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .mod_q_i         (mod_q),
    .mod_nxt_i       (mod_nxt),
    .mod_req_valid_i (mod_req_valid_i),
    .req_valid_i     (vid_req_valid_i),
    .req_i           (vid_req_i),
    .vid_q_o         (vid_q),
    .bad_o           (vid_bad)
  );

  err_latch #(.NumSrc(2)) u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  ({vid_bad, mod_bad}),
    .clr_i  (err_clr_i),
    .err_o  (err_o)
  );

  assign bias_en_o   = (mod_q != MOD_OFF);
  assign seq_en_o    = (mod_q == MOD_SEQ);
  assign mod_state_o = mod_q;
  assign vid_state_o = vid_q;
endmodule

// File: rtl/acq_mode_supervisor_chk.sv
module acq_mode_supervisor_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mod_req_valid_i,
  input logic [1:0] mod_req_i,
  input logic       vid_req_valid_i,
  input logic [1:0] vid_req_i,
  input logic       err_clr_i,
  input logic       bias_en_o,
  input logic       seq_en_o,
  input logic [1:0] mod_state_o,
  input logic [1:0] vid_state_o,
  input logic       err_o
);
  // R1
  code_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_state_o != 2'd3);

  // R2
  off_inactive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_state_o == 2'd0 |-> !bias_en_o && !seq_en_o && vid_state_o == 2'd0);

  // R2
  off_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_state_o == 2'd0 |=> mod_state_o != 2'd2);

  // R5
  oper_needs_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vid_state_o == 2'd3 |-> seq_en_o);

  // R6
  vid_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vid_state_o != 2'd0 |=> vid_state_o == $past(vid_state_o) || vid_state_o == 2'd0);

  // R8
  bad_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_req_valid_i && mod_req_i == 2'd3 |=> err_o && $stable(mod_state_o));

  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !err_clr_i |=> err_o);

  // R10
  collide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_req_valid_i && vid_req_valid_i |=> err_o);

  // R10
  collide_vid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_req_valid_i && vid_req_valid_i && mod_req_i != 2'd0 && mod_req_i != 2'd3
    && !(mod_state_o == 2'd2 && mod_req_i == 2'd1 && vid_state_o == 2'd3)
    && !(mod_state_o == 2'd0 && mod_req_i == 2'd2)
    |=> $stable(vid_state_o));
endmodule

bind acq_mode_supervisor acq_mode_supervisor_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .mod_req_valid_i (mod_req_valid_i),
  .mod_req_i       (mod_req_i),
  .vid_req_valid_i (vid_req_valid_i),
  .vid_req_i       (vid_req_i),
  .err_clr_i       (err_clr_i),
  .bias_en_o       (bias_en_o),
  .seq_en_o        (seq_en_o),
  .mod_state_o     (mod_state_o),
  .vid_state_o     (vid_state_o),
  .err_o           (err_o)
);

// File: tb/acq_mode_supervisor_test.sv
module acq_mode_supervisor_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mod_req_valid_i = 1'b0;
  logic [1:0] mod_req_i = 2'd0;
  logic       vid_req_valid_i = 1'b0;
  logic [1:0] vid_req_i = 2'd0;
  logic       err_clr_i = 1'b0;
  logic       bias_en_o, seq_en_o, err_o;
  logic [1:0] mod_state_o, vid_state_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  acq_mode_supervisor uut (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .mod_req_valid_i (mod_req_valid_i),
    .mod_req_i       (mod_req_i),
    .vid_req_valid_i (vid_req_valid_i),
    .vid_req_i       (vid_req_i),
    .err_clr_i       (err_clr_i),
    .bias_en_o       (bias_en_o),
    .seq_en_o        (seq_en_o),
    .mod_state_o     (mod_state_o),
    .vid_state_o     (vid_state_o),
    .err_o           (err_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // one request cycle; outputs sampled at the following negedge
  task automatic drive(input bit mv, input int mr, input bit vv, input int vr, input bit clr);
    @(negedge clk_i);
    mod_req_valid_i = mv;
    mod_req_i       = 2'(mr);
    vid_req_valid_i = vv;
    vid_req_i       = 2'(vr);
    err_clr_i       = clr;
    @(negedge clk_i);
    mod_req_valid_i = 1'b0;
    vid_req_valid_i = 1'b0;
    err_clr_i       = 1'b0;
  endtask

  task automatic goto_state(input int m, input int v);
    do_reset();
    if (m >= 1) drive(1, 1, 0, 0, 0);
    if (m == 2) drive(1, 2, 0, 0, 0);
    if (v != 0) drive(0, 0, 1, v, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 mod", mod_state_o, 0);
    chk("R1 vid", vid_state_o, 0);
    chk("R1 err", err_o, 0);
    chk("R1 bias", bias_en_o, 0);
    chk("R1 seq", seq_en_o, 0);

    // R11 latency: no change before the edge
    @(negedge clk_i);
    mod_req_valid_i = 1'b1;
    mod_req_i = 2'd1;
    #1;
    chk("R11 before edge", mod_state_o, 0);
    @(negedge clk_i);
    mod_req_valid_i = 1'b0;
    chk("R11 after edge", mod_state_o, 1);

    // R2 R3 R4 R5 R6 R7 R8 exhaustive sweep
    for (int m = 0; m < 3; m++) begin
      for (int v = 0; v < 4; v++) begin
        if (m == 0 && v != 0) continue;
        if (m == 1 && v == 3) continue;
        for (int kind = 0; kind < 2; kind++) begin
          for (int r = 0; r < 4; r++) begin
            bit legal;
            int nm, nv;
            goto_state(m, v);
            if (kind == 0) begin
              legal = (m == 0) ? (r == 0 || r == 1) : (r != 3);
              nm = legal ? r : m;
              if (nm == 0) nv = 0;
              else if (m == 2 && nm == 1 && v == 3) nv = 0;
              else nv = v;
              drive(1, r, 0, 0, 0);
              chk($sformatf("R2 R3 R4 R7 R8 mod m%0d v%0d r%0d state", m, v, r), mod_state_o, nm);
              chk($sformatf("R7 mod m%0d v%0d r%0d vid", m, v, r), vid_state_o, nv);
              chk($sformatf("R8 mod m%0d v%0d r%0d err", m, v, r), err_o, legal ? 0 : 1);
              chk($sformatf("R2 R3 R4 m%0d r%0d bias", m, r), bias_en_o, nm != 0);
              chk($sformatf("R2 R3 R4 m%0d r%0d seq", m, r), seq_en_o, nm == 2);
            end else begin
              legal = (m != 0) && ((r == v) || (v == 0 && (r != 3 || m == 2)) || (v != 0 && r == 0));
              nv = legal ? r : v;
              drive(0, 0, 1, r, 0);
              chk($sformatf("R2 R5 R6 R8 vid m%0d v%0d r%0d state", m, v, r), vid_state_o, nv);
              chk($sformatf("R8 vid m%0d v%0d r%0d mod", m, v, r), mod_state_o, m);
              chk($sformatf("R8 vid m%0d v%0d r%0d err", m, v, r), err_o, legal ? 0 : 1);
            end
          end
        end
      end
    end

    // R7 explicit: SEQ/CAL to ON keeps CAL
    goto_state(2, 2);
    drive(1, 1, 0, 0, 0);
    chk("R7 keep cal", vid_state_o, 2);

    // R9 sticky error and clear
    goto_state(1, 0);
    drive(0, 0, 1, 3, 0);
    chk("R9 set", err_o, 1);
    drive(0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0);
    chk("R9 hold", err_o, 1);
    drive(0, 0, 0, 0, 1);
    chk("R9 clear", err_o, 0);
    drive(0, 0, 0, 0, 0);
    drive(1, 3, 0, 0, 1);
    chk("R9 set beats clear", err_o, 1);
    drive(0, 0, 0, 0, 1);
    chk("R9 clear again", err_o, 0);

    // R10 collision
    goto_state(1, 0);
    drive(1, 2, 1, 1, 0);
    chk("R10 mod applied", mod_state_o, 2);
    chk("R10 vid rejected", vid_state_o, 0);
    chk("R10 err", err_o, 1);
    goto_state(2, 1);
    drive(1, 2, 1, 0, 0);
    chk("R10 vid kept", vid_state_o, 1);
    chk("R10 err2", err_o, 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule